// File: doc/BRIEF.md
# Laser Round-Trip Range Counter

This block times a laser round trip in clock cycles and reports half of that time as a distance value. A press of the start button fires the laser for exactly one clock. The block then counts clock cycles until the return sensor reports the echo. Half of the count is then written to a result register, which drives the distance output. The result stays on the output until the next measurement completes. Conversion to physical units and the display belong to the surrounding system.

Internally, a Moore controller drives four control strobes into a datapath. The control strobes are: result clear, result load, counter clear and counter enable. The datapath holds an up-counter, a result register and a right shift by one bit on the load path. The controller returns to its waiting state after every measurement, so measurements can be repeated without a reset.

Top module: `laser_range_top`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge forces `laser_o` to 0 and `dist_o` to 0. This also holds in the middle of a measurement.
- R2: While waiting and with `btn_i` low, `laser_o` stays 0 and `dist_o` keeps its last value.
- R3: If `btn_i` is sampled high at an edge while waiting, `laser_o` is 1 for exactly the next clock cycle and 0 afterwards. `laser_o` never rises without `btn_i` being high at the preceding edge.
- R4: Let E be the edge that ends the laser cycle. If `echo_i` is first sampled high at edge E+n (n ≥ 1), the new distance is n shifted right by one bit.
- R5: `dist_o` takes the new value at edge E+n+1 and stays unchanged at every other edge until the next measurement completes.
- R6: The cycle count wraps modulo 2^16. It does not saturate and raises no flag, so n = 65536 yields a distance of 0 and n = 65535 yields 32767.
- R7: `echo_i` has no effect outside the counting phase. While waiting it neither changes `dist_o` nor fires the laser.
- R8: `btn_i` has no effect during a measurement. After the result is stored, the block is waiting again and a new press starts a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge (300 MHz target) |
| rst | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Start request, already synchronized to clk |
| echo_i | input | 1 | Return sensor, already synchronized to clk |
| laser_o | output | 1 | Laser fire strobe, one cycle wide |
| dist_o | output | 16 | Measured distance: half of the round-trip cycle count |

## Verification
The assertions assume that `btn_i` and `echo_i` are synchronous to `clk` and are never sampled while changing. They also assume that reset is held for at least one rising edge before a measurement is judged. The stimulus respects this by changing every input only on the falling edge, with reset asserted for several edges at start-up and for the mid-measurement case. Random phases vary the idle length, the echo delay, sensor noise while waiting and button presses while counting. Directed cases cover the shortest echo and both sides of the wrap point.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_FIRE  = 3'd2,
        ST_COUNT = 3'd3,
        ST_STORE = 3'd4
    } lrm_state_e;

    typedef struct packed {
        logic res_clr;
        logic res_ld;
        logic cnt_clr;
        logic cnt_en;
        logic laser;
    } lrm_ctl_t;

endpackage

// File: rtl/lrm_ctrl.sv
module lrm_ctrl
    import lrm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       btn,
    input  logic       echo,
    output lrm_ctl_t   ctl,
    output lrm_state_e state
);

    typedef struct packed {
        lrm_state_e st;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    // next-state logic
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_INIT:  r_d.st = ST_IDLE;
            ST_IDLE:  r_d.st = btn ? ST_FIRE : ST_IDLE;
            ST_FIRE:  r_d.st = ST_COUNT;
            ST_COUNT: r_d.st = echo ? ST_STORE : ST_COUNT;
            ST_STORE: r_d.st = ST_IDLE;
            default:  r_d.st = ST_INIT;
        endcase
    end

    // Moore strobes; anything not named is 0
    always_comb begin
        ctl = '0;
        unique case (r_q.st)
            ST_INIT:  ctl.res_clr = 1'b1;
            ST_IDLE:  ctl.cnt_clr = 1'b1;
            ST_FIRE:  ctl.laser   = 1'b1;
            ST_COUNT: ctl.cnt_en  = 1'b1;
            ST_STORE: ctl.res_ld  = 1'b1;
            default:  ctl         = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: ST_INIT};
        else     r_q <= r_d;
    end

    assign state = r_q.st;

endmodule

// File: rtl/lrm_counter.sv
module lrm_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    // wraps naturally at all-ones
    always_comb begin
        r_d = r_q;
        if (clr)     r_d.cnt = '0;
        else if (en) r_d.cnt = r_q.cnt + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign cnt = r_q.cnt;

endmodule

// File: rtl/lrm_result.sv
module lrm_result #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } res_regs_t;

    res_regs_t r_d, r_q;
    logic [W-1:0] half;

    // round trip to one-way: drop the LSB
    assign half = {1'b0, din[W-1:1]};

    always_comb begin
        r_d = r_q;
        if (clr)     r_d.val = '0;
        else if (ld) r_d.val = half;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign q = r_q.val;

endmodule

// File: rtl/laser_range_top.sv
module laser_range_top
    import lrm_pkg::*;
#(
    parameter int unsigned DIST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_i,
    input  logic              echo_i,
    output logic              laser_o,
    output logic [DIST_W-1:0] dist_o
);

    lrm_ctl_t          ctl_w;
    lrm_state_e        state_w;
    logic [DIST_W-1:0] count_w;

    lrm_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .btn   (btn_i),
        .echo  (echo_i),
        .ctl   (ctl_w),
        .state (state_w)
    );

    lrm_counter #(.W(DIST_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctl_w.cnt_clr),
        .en  (ctl_w.cnt_en),
        .cnt (count_w)
    );

    lrm_result #(.W(DIST_W)) u_res (
        .clk (clk),
        .rst (rst),
        .clr (ctl_w.res_clr),
        .ld  (ctl_w.res_ld),
        .din (count_w),
        .q   (dist_o)
    );

    assign laser_o = ctl_w.laser;

endmodule

// File: rtl/laser_range_checker.sv
module laser_range_checker
    import lrm_pkg::*;
#(
    parameter int unsigned DIST_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              btn_i,
    input logic              echo_i,
    input logic              laser_o,
    input logic [DIST_W-1:0] dist_o,
    input lrm_state_e        state,
    input logic [DIST_W-1:0] count
);

    p_laser_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        laser_o |=> !laser_o);

    p_laser_needs_btn_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(laser_o) |-> $past(btn_i));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !btn_i) |=> (state == ST_IDLE && !laser_o));

    p_dist_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_STORE) |=> $stable(dist_o));

    p_count_starts_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIRE) |-> (count == '0));

    p_echo_ends_count_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && echo_i) |=> (state == ST_STORE));

    p_dist_half_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE) |=> (dist_o == ($past(count) >> 1)));

    p_btn_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && !echo_i) |=> (state == ST_COUNT));

endmodule

bind laser_range_top laser_range_checker #(.DIST_W(DIST_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .btn_i   (btn_i),
    .echo_i  (echo_i),
    .laser_o (laser_o),
    .dist_o  (dist_o),
    .state   (state_w),
    .count   (count_w)
);

// File: tb/laser_range_top_bench.sv
module laser_range_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn_i = 1'b0;
    logic        echo_i = 1'b0;
    logic        laser_o;
    logic [15:0] dist_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] exp_dist = 16'd0;

    laser_range_top u_laser_range_top (
        .clk     (clk),
        .rst     (rst),
        .btn_i   (btn_i),
        .echo_i  (echo_i),
        .laser_o (laser_o),
        .dist_o  (dist_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // expected distance for n counted edges (R4, R6)
    function automatic logic [15:0] model_dist(input longint n);
        logic [15:0] wrapped;
        wrapped = n[15:0];
        return wrapped >> 1;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R2, R7: waiting with noise on echo
    task automatic idle_phase(input int k, input bit noise);
        for (int i = 0; i < k; i++) begin
            btn_i  = 1'b0;
            echo_i = noise ? 1'($urandom_range(0, 1)) : 1'b0;
            tick();
            chk(laser_o == 1'b0, "R7 laser while waiting", laser_o, 0);
            chk(dist_o == exp_dist, "R2 dist held while waiting", dist_o, exp_dist);
        end
        echo_i = 1'b0;
    endtask

    // m echo-low edges, then echo high: n = m + 1
    task automatic measure(input int m, input bit btn_noise);
        logic [15:0] old_dist;
        old_dist = dist_o;
        btn_i  = 1'b1;
        echo_i = 1'b0;
        tick();
        btn_i = 1'b0;
        chk(laser_o == 1'b1, "R3 laser fires after press", laser_o, 1);
        tick();
        chk(laser_o == 1'b0, "R3 laser one cycle wide", laser_o, 0);
        for (int i = 0; i < m; i++) begin
            echo_i = 1'b0;
            btn_i  = btn_noise ? 1'($urandom_range(0, 1)) : 1'b0;
            tick();
            if (i < 64 || i == m - 1) begin
                chk(laser_o == 1'b0, "R8 no refire while counting", laser_o, 0);
                chk(dist_o == old_dist, "R5 dist held while counting", dist_o, old_dist);
            end
        end
        echo_i = 1'b1;
        btn_i  = 1'b0;
        tick();
        echo_i = 1'b0;
        chk(dist_o == old_dist, "R5 dist held at echo edge", dist_o, old_dist);
        tick();
        exp_dist = model_dist(longint'(m) + 1);
        chk(dist_o == exp_dist, (m >= 65534) ? "R6 wrap distance" : "R4 distance value",
            dist_o, exp_dist);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) tick();
        chk(laser_o == 1'b0, "R1 reset laser", laser_o, 0);
        chk(dist_o == 16'd0, "R1 reset dist", dist_o, 0);
        rst = 1'b0;
        tick();
        idle_phase(4, 1'b0);

        // directed shortest echoes
        measure(0, 1'b0);
        idle_phase(3, 1'b1);
        measure(1, 1'b0);
        idle_phase(2, 1'b1);
        measure(6, 1'b1);

        // back-to-back: R8 new press right after store
        measure(9, 1'b0);

        // random phases
        for (int t = 0; t < 40; t++) begin
            idle_phase($urandom_range(0, 6), 1'b1);
            measure($urandom_range(0, 300), 1'b1);
        end

        // wrap boundaries (R6)
        measure(65534, 1'b0);
        idle_phase(2, 1'b0);
        measure(65535, 1'b0);
        idle_phase(2, 1'b0);
        measure(20, 1'b0);

        // reset during counting (R1)
        btn_i = 1'b1;
        tick();
        btn_i = 1'b0;
        repeat (5) tick();
        rst = 1'b1;
        tick();
        chk(dist_o == 16'd0, "R1 mid-measure reset dist", dist_o, 0);
        chk(laser_o == 1'b0, "R1 mid-measure reset laser", laser_o, 0);
        rst = 1'b0;
        exp_dist = 16'd0;
        tick();
        idle_phase(3, 1'b1);
        measure(13, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule